// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins (up to 32). Software reaches it through a plain single-cycle register bus: a byte address, a write strobe, 32-bit write data and a combinational 32-bit read data. Each pin is set as an input or an output by a direction register. Output levels come from a data register, and reading that same register returns the present level of every pin.

Every input runs through a two-flop synchronizer. A per-pin detector then turns the synchronized level into an interrupt event. Three per-pin control bits choose the trigger: level versus edge, polarity, and a both-edges override. Events collect in sticky pending bits, which software clears by writing ones to a clear register. Pending bits that are also enabled form the status word, and the status bits are ORed into one interrupt line. A read-only version register reports 3 or higher, which tells software that both-edge triggering is present.

The detector is built around a three-way trigger kind: `TRIG_LEVEL`, `TRIG_EDGE_ONE` and `TRIG_EDGE_BOTH`. Each pin re-selects its kind every cycle from its control bits. There are no sequenced states beyond this selection.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction register reads all ones (every pin an input). The enable, edge-select, polarity and both-edge registers read 0. The status register reads 0 and `irq` is low.
- R2: Direction register (offset 0x04): a 1 makes pin i an input and a 0 makes it an output. `pin_oe[i]` is the inverse of the direction bit, and `pin_out` equals the data register (offset 0x00), one cycle after the write.
- R3: Reading offset 0x00 returns, for each pin, its synchronized `pin_in` level if the pin is an input, or its driven data bit if the pin is an output. Bits N and above read 0.
- R4: With the edge-select bit (offset 0x18) at 0, the pin is level-triggered. A polarity bit (offset 0x1C) of 1 is active high and 0 is active low. The pending bit is set on every cycle the active level is present, so it is set again right after a clear while the level persists.
- R5: With edge-select 1 and both-edge bit (offset 0x24) 0, polarity 1 triggers on a rising edge and polarity 0 on a falling edge. An edge is the synchronized level differing from its value one cycle earlier. A set pending bit stays set until cleared.
- R6: With both-edge 1 and edge-select 1, either edge triggers and polarity is ignored. With both-edge 1 and edge-select 0, the pin stays level-triggered.
- R7: Writing offset 0x14 clears every pending bit (offset 0x10) whose write-data bit is 1 and leaves the pins written with 0 unchanged. An event in the same cycle as the clear wins.
- R8: The status register (offset 0x0C) reads pending AND enable (offset 0x08), and `irq` is the OR of status. With enable all zeros `irq` stays low while the pending bits are kept.
- R9: The version register (offset 0x20) reads the VERSION parameter (default 3). Writes to the version, status and pending offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pin_in | input | N | Pin levels from the pads |
| pin_out | output | N | Driven levels for output pins |
| pin_oe | output | N | Output enable per pin, 1 = drive |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an event landing in the very cycle that software clears the pin. Only then does set-over-clear priority show. Level-triggered pins at their active level create this case on every clear, so the random loop writes an all-ones clear while such pins are held active and expects exactly those bits to stay set. A later partial clear checks that zero bits leave pending untouched. Edge cases come from pin words that change in one step after a settled previous word, so every pin has a known old and new level under a random trigger setting.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int REG_ADDR_W = 6;
    localparam int BUS_W      = 32;

    typedef logic [REG_ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t OFS_DATA = 6'h00;
    localparam reg_addr_t OFS_DIR  = 6'h04;
    localparam reg_addr_t OFS_IEN  = 6'h08;
    localparam reg_addr_t OFS_STAT = 6'h0C;
    localparam reg_addr_t OFS_PEND = 6'h10;
    localparam reg_addr_t OFS_CLR  = 6'h14;
    localparam reg_addr_t OFS_MODE = 6'h18;
    localparam reg_addr_t OFS_POL  = 6'h1C;
    localparam reg_addr_t OFS_VER  = 6'h20;
    localparam reg_addr_t OFS_BOTH = 6'h24;

    typedef enum logic [1:0] {
        TRIG_LEVEL     = 2'd0,
        TRIG_EDGE_ONE  = 2'd1,
        TRIG_EDGE_BOTH = 2'd2
    } trig_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic mode_edge,
    input  logic pol_high,
    input  logic both_edge,
    output logic evt
);
    logic       prev_q;
    trig_kind_e kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        if (!mode_edge)     kind = TRIG_LEVEL;
        else if (both_edge) kind = TRIG_EDGE_BOTH;
        else                kind = TRIG_EDGE_ONE;
    end

    always_comb begin
        unique case (kind)
            TRIG_LEVEL:     evt = ~(lvl ^ pol_high);
            TRIG_EDGE_ONE:  evt = pol_high ? (lvl & ~prev_q) : (~lvl & prev_q);
            TRIG_EDGE_BOTH: evt = lvl ^ prev_q;
            default:        evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int N       = 32,
    parameter int VERSION = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic [N-1:0]          pin_in,
    output logic [N-1:0]          pin_out,
    output logic [N-1:0]          pin_oe,
    output logic                  irq
);
    localparam int PAD = BUS_W - N;

    logic [N-1:0] dout_q, dir_q, ien_q, mode_q, pol_q, both_q, pend_q;
    logic [N-1:0] sync_q, evt, clr_mask, stat, pin_view;
    logic [N-1:0] wd;

    assign wd = bus_wdata[N-1:0];

    gpio_sync #(.W(N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_q)
    );

    for (genvar i = 0; i < N; i++) begin : g_pin
        gpio_trig_det u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (sync_q[i]),
            .mode_edge (mode_q[i]),
            .pol_high  (pol_q[i]),
            .both_edge (both_q[i]),
            .evt       (evt[i])
        );
    end

    assign clr_mask = (bus_we && bus_addr == OFS_CLR) ? wd : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '1;
            ien_q  <= '0;
            mode_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | evt;
            if (bus_we) begin
                unique case (bus_addr)
                    OFS_DATA: dout_q <= wd;
                    OFS_DIR:  dir_q  <= wd;
                    OFS_IEN:  ien_q  <= wd;
                    OFS_MODE: mode_q <= wd;
                    OFS_POL:  pol_q  <= wd;
                    OFS_BOTH: both_q <= wd;
                    default:  ;
                endcase
            end
        end
    end

    assign stat     = pend_q & ien_q;
    assign irq      = |stat;
    assign pin_out  = dout_q;
    assign pin_oe   = ~dir_q;
    assign pin_view = (dir_q & sync_q) | (~dir_q & dout_q);

    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = {{PAD{1'b0}}, pin_view};
            OFS_DIR:  bus_rdata = {{PAD{1'b0}}, dir_q};
            OFS_IEN:  bus_rdata = {{PAD{1'b0}}, ien_q};
            OFS_STAT: bus_rdata = {{PAD{1'b0}}, stat};
            OFS_PEND: bus_rdata = {{PAD{1'b0}}, pend_q};
            OFS_MODE: bus_rdata = {{PAD{1'b0}}, mode_q};
            OFS_POL:  bus_rdata = {{PAD{1'b0}}, pol_q};
            OFS_BOTH: bus_rdata = {{PAD{1'b0}}, both_q};
            OFS_VER:  bus_rdata = BUS_W'(VERSION);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_pkg::*;
#(
    parameter int N = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic                  bus_we,
    input logic [BUS_W-1:0]      bus_wdata,
    input logic [N-1:0]          pin_oe,
    input logic                  irq,
    input logic [N-1:0]          ien_q,
    input logic [N-1:0]          mode_q,
    input logic [N-1:0]          pol_q,
    input logic [N-1:0]          pend_q,
    input logic [N-1:0]          sync_q,
    input logic [N-1:0]          evt
);
    logic         clr_hit;
    logic [N-1:0] clr_bits;

    assign clr_hit  = bus_we && (bus_addr == OFS_CLR);
    assign clr_bits = clr_hit ? bus_wdata[N-1:0] : '0;

    assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DIR) |=> (pin_oe == ~$past(bus_wdata[N-1:0])));

    assert_level_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(~mode_q & ~(sync_q ^ pol_q)) & ~pend_q) == '0));

    assert_pending_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~pend_q & $past(pend_q & ~clr_bits)) == '0));

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((pend_q & $past(clr_bits & ~evt)) == '0));

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .ien_q     (ien_q),
    .mode_q    (mode_q),
    .pol_q     (pol_q),
    .pend_q    (pend_q),
    .sync_q    (sync_q),
    .evt       (evt)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.N(N), .VERSION(3)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
    endtask

    // level-active pins: edge-select 0 and level matches polarity
    function automatic logic [31:0] lvl_act(input logic [31:0] v, input logic [31:0] md,
                                            input logic [31:0] pl);
        return ~md & ~(v ^ pl);
    endfunction

    // edge events for a single step from a to b
    function automatic logic [31:0] edge_evt(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] md, input logic [31:0] pl,
                                             input logic [31:0] bo);
        logic [31:0] rise, fall;
        rise = b & ~a;
        fall = ~b & a;
        return md & ((bo & (rise | fall)) | (~bo & ((pl & rise) | (~pl & fall))));
    endfunction

    task automatic cfg(input logic [31:0] md, input logic [31:0] pl,
                       input logic [31:0] bo, input logic [31:0] ie);
        wr(6'h18, md); wr(6'h1C, pl); wr(6'h24, bo); wr(6'h08, ie);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, a, b, md, pl, bo, ie, m, expp, p;
        void'($urandom(32'd1234));
        waitc(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(6'h04, d); chk("R1 dir", d, 32'hFFFF_FFFF);
        rd(6'h08, d); chk("R1 ien", d, 0);
        rd(6'h18, d); chk("R1 mode", d, 0);
        rd(6'h1C, d); chk("R1 pol", d, 0);
        rd(6'h24, d); chk("R1 both", d, 0);
        rd(6'h0C, d); chk("R1 status", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 / R3 direction and data
        wr(6'h04, 32'h0000_FFFF);
        wr(6'h00, 32'hA5A5_5A5A);
        pin_in = 32'h1234_C3C3;
        waitc(4);
        chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        chk("R2 pin_out", pin_out, 32'hA5A5_5A5A);
        rd(6'h00, d); chk("R3 data read", d, 32'hA5A5_C3C3);
        wr(6'h04, 32'hFFFF_FFFF);
        waitc(1);
        rd(6'h00, d); chk("R3 all inputs", d, 32'h1234_C3C3);

        // R9 version and read-only offsets
        rd(6'h20, d); chk("R9 version", d, 3);
        wr(6'h20, 0);
        rd(6'h20, d); chk("R9 version write ignored", d, 3);
        cfg(32'hFFFF_FFFF, 0, 0, 0);   // all single falling edge, no events while stable
        wr(6'h14, 32'hFFFF_FFFF);
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h0C, 32'hFFFF_FFFF);
        rd(6'h10, d); chk("R9 pending write ignored", d, 0);

        // R6 directed: both edges with polarity 0 sees a rising edge
        cfg(32'h0000_0001, 32'h0, 32'h0000_0003, 0);
        pin_in = 32'h0;
        waitc(4);
        wr(6'h14, 32'hFFFF_FFFF);
        pin_in = 32'h0000_0001;
        waitc(4);
        rd(6'h10, d);
        // bit1 is level-low (mode 0) even with both set; bit0 caught the rise
        chk("R6 both-edge rise polarity ignored", d & 32'h3, 32'h3);

        // R8 directed: enable zero keeps pending, irq low
        rd(6'h0C, d); chk("R8 status masked", d, 0);
        chk("R8 irq masked", {31'd0, irq}, 0);
        wr(6'h08, 32'h0000_0001);
        chk("R8 irq on enable", {31'd0, irq}, 1);
        wr(6'h08, 0);
        rd(6'h10, d); chk("R8 pending kept", d & 32'h1, 1);

        // R4 directed: level re-sets after clear
        cfg(0, 32'h0000_0010, 0, 0);
        pin_in = 32'h0000_0010;
        waitc(4);
        wr(6'h14, 32'h0000_0010);
        rd(6'h10, d); chk("R4 level reset after clear", d & 32'h10, 32'h10);

        // random mixed rounds: R4 R5 R6 R7 R8
        for (int it = 0; it < 60; it++) begin
            md = $urandom; pl = $urandom; bo = $urandom; ie = $urandom;
            a = $urandom; b = $urandom; m = $urandom;
            if (it % 7 == 0) ie = 0;
            cfg(md, pl, bo, ie);
            pin_in = a;
            waitc(5);
            wr(6'h14, 32'hFFFF_FFFF);
            rd(6'h10, d); chk("R7 clear with level set-wins (R4)", d, lvl_act(a, md, pl));
            pin_in = b;
            waitc(5);
            expp = lvl_act(a, md, pl) | lvl_act(b, md, pl) | edge_evt(a, b, md, pl, bo);
            rd(6'h10, d); chk("R5 R6 pending after step", d, expp);
            rd(6'h0C, d); chk("R8 status", d, expp & ie);
            chk("R8 irq", {31'd0, irq}, {31'd0, |(expp & ie)});
            wr(6'h14, m);
            p = (expp & ~m) | lvl_act(b, md, pl);
            rd(6'h10, d); chk("R7 partial clear", d, p);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule